// File: doc/BRIEF.md
# Interrupt Return Flag Restore Unit

This unit carries out the hardware side of leaving an interrupt handler. A single start strobe begins the sequence. The unit latches the current flags word, the current privilege ring and the stack pointer. It then fetches three stack words through a synchronous read port, one per clock: the resume address, the code selector and the saved flags image. One cycle after the last word returns, it presents the rebuilt flags word, the resume address, the selector and the advanced stack pointer together, and it raises `done` for a single cycle.

Most of the flags word is copied from the saved image. Two fields are different. The two-bit I/O privilege field can only be reloaded by code running in ring 0. The interrupt-enable bit can only be reloaded when the current ring is numerically at or below the I/O privilege level that was in force before the return. If a guard fails, the current value of the field is kept. Reserved bits take fixed values.

The controller has five states. `ST_IDLE` waits for `start`. The transition `accept` (start while idle) goes to `ST_FETCH_IP`, which reads the word at the stack pointer. `ST_FETCH_SEL` reads the word at +4 and captures the resume address. `ST_FETCH_FLG` reads the word at +8 and captures the selector. `ST_COMMIT` merges the flags image that has arrived, and its unconditional `finish` transition registers all results, pulses `done` and returns to `ST_IDLE`. All other transitions are unconditional steps from one fetch state to the next.

Top module: `irq_return_unit`

## Requirements
- R1: After `start` is accepted at clock edge N, `rd_en` is high for exactly the three cycles after edges N, N+1 and N+2. In those cycles `rd_addr` is the latched stack pointer, then the pointer plus 4, then the pointer plus 8. `rd_en` is never high in any other cycle. Read data appears on `rd_data` one cycle after the address.
- R2: `done` is high for exactly one cycle, the cycle after edge N+4. At that point `ret_ip` equals the first word read and `ret_sel` equals the low 16 bits of the second word read. The outputs hold their values until the next commit.
- R3: `ret_sp` equals the latched stack pointer plus 12.
- R4: Flags bits 13:12 (I/O privilege level) are taken from the image when `cur_ring` is 0. Otherwise they keep the value from `cur_flags`.
- R5: Flags bit 9 (interrupt enable) is taken from the image when `cur_ring` is less than or equal to `cur_flags[13:12]`, which is the level before the return. Otherwise it keeps the value from `cur_flags`.
- R6: Flags bit 8 (single-step trap) and every other defined bit in mask 0x00037FD5, apart from bits 13:12 and bit 9, are copied from the image without condition.
- R7: In `ret_flags`, bit 1 is always 1 and every bit outside mask 0x00037FD5 other than bit 1 is 0.
- R8: A `start` that arrives while the unit is busy (edges N+1 to N+4) is ignored. It causes no extra read, no extra `done`, and no change to the latched inputs. A `start` that arrives in the `done` cycle is accepted.
- R9: After reset, `done` and `rd_en` are 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a return sequence |
| cur_flags | input | 32 | Flags word in force before the return |
| cur_ring | input | 2 | Current privilege ring (0 is most privileged) |
| cur_sp | input | ADDR_W | Stack pointer at the resume-address word |
| rd_en | output | 1 | Stack read request |
| rd_addr | output | ADDR_W | Stack read byte address |
| rd_data | input | 32 | Stack read data, one cycle after the request |
| ret_flags | output | 32 | Rebuilt flags word |
| ret_ip | output | 32 | Resume address |
| ret_sel | output | SEL_W | Resume code selector |
| ret_sp | output | ADDR_W | Stack pointer after the three words |
| done | output | 1 | One-cycle pulse when the results are valid |

## Verification
The bench places images whose privilege and enable fields differ from the current flags. It runs them at rings 0, 1 and 3 with different current levels. A design that swaps or drops either guard, or that checks the enable bit against the wrong ring comparison, delivers the wrong bit 9 or bits 13:12. It also uses images with every reserved bit set, and images with all bits clear. A design that forgets to force a reserved bit therefore leaks it into the result. Extra starts are sent in the middle of a fetch and in the commit cycle, and a new start is sent in the same cycle as `done`. If the unit restarts while busy, the bench sees unexpected read addresses or a stray `done`. If it misses the back-to-back start, a result is lost. Selector words carry junk in their upper half, and the address and latency of every read are compared against the expected values, which catches truncation and off-by-one timing.

// File: rtl/irtn_pkg.sv
package irtn_pkg;

    // Flags word geometry (field positions are decoded by neighbouring logic).
    localparam int FLG_W      = 32;
    localparam int BIT_FIXED1 = 1;
    localparam int BIT_STEP   = 8;
    localparam int BIT_IRQEN  = 9;
    localparam int LVL_LO     = 12;
    localparam int LVL_HI     = 13;
    localparam int RING_W     = 2;

    // Bits that carry architectural meaning; the rest are reserved.
    localparam logic [FLG_W-1:0] DEFINED_MASK = 32'h0003_7FD5;

    // Number of stack words popped by one return.
    localparam int POP_WORDS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_IP,
        ST_FETCH_SEL,
        ST_FETCH_FLG,
        ST_COMMIT
    } irtn_state_e;

    // Source of each bit of the rebuilt flags word.
    typedef enum logic [2:0] {
        SRC_IMAGE,
        SRC_ZERO,
        SRC_ONE,
        SRC_LVL_GATED,
        SRC_IRQ_GATED
    } bit_src_e;

    function automatic bit_src_e bit_source(input int b);
        if (b == BIT_FIXED1)              return SRC_ONE;
        if (b == BIT_IRQEN)               return SRC_IRQ_GATED;
        if (b >= LVL_LO && b <= LVL_HI)   return SRC_LVL_GATED;
        if (DEFINED_MASK[b])              return SRC_IMAGE;
        return SRC_ZERO;
    endfunction

endpackage

// File: rtl/irtn_seq.sv
module irtn_seq
    import irtn_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_sp,
    output irtn_state_e       state,
    output logic              accept,
    output logic              commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    irtn_state_e state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;

    // State register and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                ptr_q <= base_sp;
            else if (rd_en)
                ptr_q <= ptr_q + STEP;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_FETCH_IP;
            ST_FETCH_IP:  state_d = ST_FETCH_SEL;
            ST_FETCH_SEL: state_d = ST_FETCH_FLG;
            ST_FETCH_FLG: state_d = ST_COMMIT;
            ST_COMMIT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        accept  = 1'b0;
        commit  = 1'b0;
        rd_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:      accept = start;
            ST_FETCH_IP,
            ST_FETCH_SEL,
            ST_FETCH_FLG: rd_en  = 1'b1;
            ST_COMMIT:    commit = 1'b1;
            default:      ;
        endcase
    end

    assign state   = state_q;
    assign rd_addr = ptr_q;

    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (state_q != ST_IDLE && state_q != ST_COMMIT)); // R1
    AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_SEL || state_q == ST_FETCH_FLG)
            |-> rd_addr == $past(rd_addr) + STEP); // R1
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=> state_q != ST_FETCH_IP); // R8

endmodule

// File: rtl/irtn_capture.sv
module irtn_capture
    import irtn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  irtn_state_e            state,
    input  logic [DATA_W-1:0]      rd_data,
    output logic [SLOTS-1:0][DATA_W-1:0] words
);

    // Slot k holds the word read in fetch step k; it arrives while the
    // controller sits in the state after that fetch.
    function automatic irtn_state_e landing_state(input int k);
        return (k == 0) ? ST_FETCH_SEL : ST_FETCH_FLG;
    endfunction

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (state == landing_state(k))
                word_q <= rd_data;
        end
        assign words[k] = word_q;
    end

endmodule

// File: rtl/irtn_flag_merge.sv
module irtn_flag_merge
    import irtn_pkg::*;
(
    input  logic [FLG_W-1:0]  image,
    input  logic [FLG_W-1:0]  cur_flags,
    input  logic [RING_W-1:0] ring,
    output logic [FLG_W-1:0]  merged
);

    logic lvl_ok;
    logic irq_ok;
    logic [RING_W-1:0] old_lvl;

    // Guards use the level in force before the return.
    assign old_lvl = cur_flags[LVL_HI:LVL_LO];
    assign lvl_ok  = (ring == '0);
    assign irq_ok  = (ring <= old_lvl);

    for (genvar b = 0; b < FLG_W; b++) begin : g_bit
        localparam bit_src_e SRC = bit_source(b);
        if (SRC == SRC_ONE) begin : g_one
            assign merged[b] = 1'b1;
        end else if (SRC == SRC_ZERO) begin : g_zero
            assign merged[b] = 1'b0;
        end else if (SRC == SRC_IMAGE) begin : g_img
            assign merged[b] = image[b];
        end else if (SRC == SRC_LVL_GATED) begin : g_lvl
            assign merged[b] = lvl_ok ? image[b] : cur_flags[b];
        end else begin : g_irq
            assign merged[b] = irq_ok ? image[b] : cur_flags[b];
        end
    end

endmodule

// File: rtl/irq_return_unit.sv
module irq_return_unit
    import irtn_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       cur_flags,
    input  logic [1:0]        cur_ring,
    input  logic [ADDR_W-1:0] cur_sp,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic [31:0]       ret_flags,
    output logic [31:0]       ret_ip,
    output logic [SEL_W-1:0]  ret_sel,
    output logic [ADDR_W-1:0] ret_sp,
    output logic              done
);

    localparam int DATA_W     = FLG_W;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] POP_BYTES = ADDR_W'(POP_WORDS * WORD_BYTES);
    localparam logic [FLG_W-1:0] RSV_ZERO = ~DEFINED_MASK & ~(FLG_W'(1) << BIT_FIXED1);

    irtn_state_e state;
    logic accept, commit;
    logic [1:0][DATA_W-1:0] words;
    logic [FLG_W-1:0]  merged;
    logic [FLG_W-1:0]  flags_q;
    logic [RING_W-1:0] ring_q;
    logic [ADDR_W-1:0] sp_q;

    irtn_seq #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .base_sp (cur_sp),
        .state   (state),
        .accept  (accept),
        .commit  (commit),
        .rd_en   (rd_en),
        .rd_addr (rd_addr)
    );

    irtn_capture #(
        .DATA_W (DATA_W),
        .SLOTS  (2)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .rd_data (rd_data),
        .words   (words)
    );

    irtn_flag_merge u_merge (
        .image     (rd_data),
        .cur_flags (flags_q),
        .ring      (ring_q),
        .merged    (merged)
    );

    // Latch the context presented with an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ring_q  <= '0;
            sp_q    <= '0;
        end else if (accept) begin
            flags_q <= cur_flags;
            ring_q  <= cur_ring;
            sp_q    <= cur_sp;
        end
    end

    // All results commit together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_flags <= '0;
            ret_ip    <= '0;
            ret_sel   <= '0;
            ret_sp    <= '0;
            done      <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                ret_flags <= merged;
                ret_ip    <= words[0];
                ret_sel   <= words[1][SEL_W-1:0];
                ret_sp    <= sp_q + POP_BYTES;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_SP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ret_sp == sp_q + POP_BYTES); // R3
    AST_LVL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ring_q != '0) |-> ret_flags[LVL_HI:LVL_LO] == flags_q[LVL_HI:LVL_LO]); // R4
    AST_IRQEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ring_q > flags_q[LVL_HI:LVL_LO]) |-> ret_flags[BIT_IRQEN] == flags_q[BIT_IRQEN]); // R5
    AST_RESERVED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ret_flags[BIT_FIXED1] && (ret_flags & RSV_ZERO) == '0)); // R7

endmodule

// File: tb/irq_return_unit_test.sv
module irq_return_unit_test;

    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;

    typedef struct {
        logic [31:0]       ip;
        logic [SEL_W-1:0]  sel;
        logic [31:0]       flags;
        logic [ADDR_W-1:0] sp;
        int                cyc;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [31:0] cur_flags = '0;
    logic [1:0]  cur_ring = '0;
    logic [ADDR_W-1:0] cur_sp = '0;
    logic rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic [31:0] ret_flags, ret_ip;
    logic [SEL_W-1:0] ret_sel;
    logic [ADDR_W-1:0] ret_sp;
    logic done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 0;

    exp_t exp_q[$];
    logic [ADDR_W-1:0] addr_q[$];
    logic [31:0] stk [logic [31:0]];

    irq_return_unit #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_flags(cur_flags),
        .cur_ring(cur_ring), .cur_sp(cur_sp), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ret_flags(ret_flags), .ret_ip(ret_ip),
        .ret_sel(ret_sel), .ret_sp(ret_sp), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) rd_data <= stk.exists(rd_addr) ? stk[rd_addr] : 32'hBAD0_BAD0;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected flags from the requirements.
    function automatic logic [31:0] model_flags(input logic [31:0] img,
                                                input logic [31:0] cur,
                                                input logic [1:0] ring);
        logic [31:0] r;
        r = img & 32'h0003_7FD5;
        r[1] = 1'b1;
        r[13:12] = (ring == 2'd0) ? img[13:12] : cur[13:12];
        r[9] = (ring <= cur[13:12]) ? img[9] : cur[9];
        return r;
    endfunction

    // Driver: caller is at a negedge; start is sampled at the next posedge.
    task automatic run_return(input logic [ADDR_W-1:0] sp, input logic [31:0] cf,
                              input logic [1:0] ring, input logic [31:0] ip,
                              input logic [31:0] sel_word, input logic [31:0] img);
        exp_t e;
        stk[sp]     = ip;
        stk[sp + 4] = sel_word;
        stk[sp + 8] = img;
        addr_q.push_back(sp);
        addr_q.push_back(sp + 4);
        addr_q.push_back(sp + 8);
        e.ip = ip; e.sel = sel_word[SEL_W-1:0];
        e.flags = model_flags(img, cf, ring);
        e.sp = sp + 12; e.cyc = cyc + 5;
        exp_q.push_back(e);
        cur_sp = sp; cur_flags = cf; cur_ring = ring; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    // Monitor / scoreboard.
    logic done_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                if (addr_q.size() == 0) check("R8", "unexpected read", rd_addr, 32'hFFFF_FFFF);
                else check("R1", "read address", rd_addr, addr_q.pop_front());
            end
            if (done && done_prev) check("R2", "done width", 32'd2, 32'd1);
            if (done) begin
                if (exp_q.size() == 0) check("R8", "stray done", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R2", "latency", cyc, e.cyc);
                    check("R2", "ret_ip", ret_ip, e.ip);
                    check("R2", "ret_sel", 32'(ret_sel), 32'(e.sel));
                    check("R3", "ret_sp", ret_sp, e.sp);
                    check("R4/R5/R6/R7", "ret_flags", ret_flags, e.flags);
                end
            end
            done_prev <= done;
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "done", 32'(done), 0);
        check("R9", "rd_en", 32'(rd_en), 0);
        check("R9", "ret_flags", ret_flags, 0);
        check("R9", "ret_sp", ret_sp, 0);
        rst_n = 1;
        @(negedge clk);
        check("R9", "done after reset", 32'(done), 0);

        // R4 R5: ring 0 takes both level and enable from image
        run_return(32'h1000, 32'h0000_0002, 2'd0, 32'h0040_1000, 32'hDEAD_0008, 32'h0000_3200);
        repeat (6) @(negedge clk);
        // R4 R5: ring 3, level 0 -> both kept
        run_return(32'h2000, 32'h0000_0002, 2'd3, 32'h0000_ABCD, 32'h1234_001B, 32'h0000_3200);
        repeat (6) @(negedge clk);
        // R5: ring 3, level 3 -> enable from image, level kept
        run_return(32'h2100, 32'h0000_3202, 2'd3, 32'h0000_1111, 32'hFFFF_0023, 32'h0000_0000);
        repeat (6) @(negedge clk);
        // R5: ring 1, level 2 -> enable from image
        run_return(32'h2200, 32'h0000_2002, 2'd1, 32'h0000_2222, 32'h0000_0033, 32'h0000_0200);
        repeat (6) @(negedge clk);
        // R5: ring 2, level 1 -> enable kept set
        run_return(32'h2300, 32'h0000_1202, 2'd2, 32'h0000_3333, 32'h0000_0043, 32'h0000_0000);
        repeat (6) @(negedge clk);
        // R6 R7: all-ones image; step trap restored, reserved forced
        run_return(32'h3000, 32'h0000_0002, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (6) @(negedge clk);
        // R6 R7: step bit and arithmetic flags from image at ring 3
        run_return(32'h3100, 32'h0000_0202, 2'd3, 32'h0000_0100, 32'h0000_0010, 32'h0000_0D55);
        repeat (6) @(negedge clk);
        // R8: starts while busy are ignored; start in done cycle accepted
        run_return(32'h4000, 32'h0000_0002, 2'd0, 32'h0000_4444, 32'h0000_0050, 32'h0001_4AD7);
        @(negedge clk);
        cur_sp = 32'h9990; cur_ring = 2'd3; start = 1;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        cur_sp = 32'h9994; start = 1;
        @(negedge clk);
        run_return(32'h5000, 32'h0000_3002, 2'd2, 32'h0000_5555, 32'h0000_0060, 32'h0000_0300);
        repeat (8) @(negedge clk);
        // R8: nothing left outstanding, outputs held after completion
        check("R8", "pending results", 32'(exp_q.size()), 0);
        check("R8", "pending reads", 32'(addr_q.size()), 0);
        check("R2", "ret_ip held", ret_ip, 32'h0000_5555);
        finish_up();
    end

endmodule